// File: doc/BRIEF.md
# Periodic Wakeup Countdown Timer

This block is a programmable periodic down-counter for a timekeeping chip. It advances on one of four prescaled tick strobes chosen by software and counts down from a 16-bit preset. Each time the count runs out, the block reloads the preset, sets a sticky event flag and, if enabled, drives a self-releasing active-low interrupt for a fixed number of system-clock cycles.

Software programs the block through a small byte-wide write port. Two addresses hold the preset bytes and a third holds the run, source and interrupt-enable controls. A fourth address clears the event flag. The prescaler that produces the ticks and the pad driver that turns the interrupt into an open-drain pin lie outside the block. A high level on the interrupt output stands for the released, high-impedance pin state.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, `timer_flag` is 0, `irq_n` is 1, the preset is 0 and the timer is stopped.
- R2: Control bits 2:1 choose the tick source: 0 for `tick_4096`, 1 for `tick_64`, 2 for `tick_1hz`, 3 for `tick_min`. Ticks on the other three inputs have no effect on the count.
- R3: After the run bit is set, the first selected tick only loads the preset, and later ticks decrement it. With preset P, the first expiry therefore happens on the (P+1)th selected tick.
- R4: An expiry happens on a tick that takes the count from 1 to 0. That tick reloads the preset and counting goes on, so later expiries come every P selected ticks.
- R5: An expiry sets `timer_flag` one cycle after its tick is sampled. The flag stays at 1 until a write to address 3 with data bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged. If an expiry and a clear arrive together, the expiry wins.
- R6: When control bit 3 (interrupt enable) is 1, each expiry drives `irq_n` low for exactly PULSE_CYC cycles, starting in the same cycle the flag sets. After that, `irq_n` returns to 1 by itself.
- R7: Clearing `timer_flag` while the interrupt pulse is active does not shorten or end the pulse.
- R8: When interrupt enable is 0, expiries still set `timer_flag`, but `irq_n` stays at 1.
- R9: Writing 0 to control bit 0 (run) stops the timer and no further expiries occur. A later restart begins with a fresh load tick, as in R3.
- R10: A preset of 0 never produces an expiry.
- R11: Address 0 holds preset bits 7:0 and address 1 holds preset bits 15:8. Address 2 holds the control byte: bit 0 is run, bits 2:1 are the source, and bit 3 is interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_4096 | input | 1 | One-cycle strobe at 4096 Hz |
| tick_64 | input | 1 | One-cycle strobe at 64 Hz |
| tick_1hz | input | 1 | One-cycle strobe at 1 Hz |
| tick_min | input | 1 | One-cycle strobe once per minute |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| timer_flag | output | 1 | Sticky expiry flag |
| irq_n | output | 1 | Active-low interrupt request; 1 means released |

## Verification
The hardest case to reach from the ports is the interaction of the interrupt pulse with a flag clear, because the clear must land inside a pulse that lasts only a few cycles. The stimulus therefore arms a short preset, delivers the final tick, and issues the clear write within the pulse window. It then checks that `irq_n` is still low after the flag has dropped. The table-driven runs also place a tick on a non-selected source after every real tick. This shows that source decoding matters, and that the load-only first tick adds exactly one period to the first expiry.

// File: rtl/wkt_pkg.sv
// Shared definitions for the wakeup countdown timer.
// Assumes the control byte layout below is fixed software contract.
package wkt_pkg;

    localparam int NUM_SRC = 4;
    localparam int SEL_W   = 2;
    localparam int CTRL_W  = 4;

    // Register addresses seen on the write port
    typedef enum logic [1:0] {
        REG_PRE_LO = 2'd0,
        REG_PRE_HI = 2'd1,
        REG_CTRL   = 2'd2,
        REG_FLAG   = 2'd3
    } reg_addr_e;

    // Tick source codes held in the control byte
    typedef enum logic [SEL_W-1:0] {
        SRC_4096 = 2'd0,
        SRC_64   = 2'd1,
        SRC_1HZ  = 2'd2,
        SRC_MIN  = 2'd3
    } src_sel_e;

    // Control byte bits 3:0: {irq_en, src[1:0], run}
    typedef struct packed {
        logic     irq_en;
        src_sel_e src;
        logic     run;
    } ctrl_t;

endpackage

// File: rtl/wkt_regs.sv
// Register file of the wakeup timer: preset bytes, control and sticky flag.
// Assumes PRESET_W is exactly two DATA_W bytes and DATA_W >= CTRL_W.
module wkt_regs
    import wkt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRESET_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                expire,
    output logic [PRESET_W-1:0] preset,
    output ctrl_t               ctrl,
    output logic                flag
);

    localparam int NBYTES = PRESET_W / DATA_W;

    // One byte lane per preset address
    for (genvar b = 0; b < NBYTES; b++) begin : g_pre
        localparam logic [1:0] BYTE_ADDR = 2'(b);
        logic [DATA_W-1:0] byte_q;

        // Capture a preset byte on a write to its address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && (wr_addr == BYTE_ADDR)) begin
                byte_q <= wr_data;
            end
        end

        assign preset[b*DATA_W +: DATA_W] = byte_q;
    end

    // Capture the control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && (wr_addr == REG_CTRL)) begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // Sticky flag: expiry sets, a zero written to bit 0 clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (wr_en && (wr_addr == REG_FLAG) && !wr_data[0]) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wkt_src_sel.sv
// Picks one tick strobe out of NUM_SRC by a binary select.
// Assumes each strobe is high for a single clock cycle.
module wkt_src_sel #(
    parameter int NSRC = 4,
    parameter int SW   = 2
) (
    input  logic [NSRC-1:0] ticks,
    input  logic [SW-1:0]   sel,
    output logic            src_tick
);

    logic [NSRC-1:0] hit;

    // Qualify each strobe by its select code
    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign hit[i] = ticks[i] && (sel == SW'(i));
    end

    assign src_tick = |hit;

endmodule

// File: rtl/wkt_counter.sv
// Periodic down-counter with load-on-first-tick and registered expiry.
// Assumes src_tick is a one-cycle strobe; a zero preset never expires.
module wkt_counter #(
    parameter int PRESET_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                src_tick,
    input  logic [PRESET_W-1:0] preset,
    output logic                expire
);

    localparam logic [PRESET_W-1:0] ONE = PRESET_W'(1);

    logic [PRESET_W-1:0] count;
    logic                loaded;
    logic                hit_one;

    assign hit_one = run && loaded && src_tick && (count == ONE);

    // Load on the first tick after run, then count down and reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            loaded <= 1'b0;
        end else if (!run) begin
            count  <= '0;
            loaded <= 1'b0;
        end else if (src_tick) begin
            if (!loaded || hit_one) begin
                count  <= preset;
                loaded <= 1'b1;
            end else if (count != '0) begin
                count <= count - ONE;
            end
        end
    end

    // Register the expiry event for a short downstream path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire <= 1'b0;
        end else begin
            expire <= hit_one;
        end
    end

endmodule

// File: rtl/wkt_pulse.sv
// Fixed-width active-low interrupt pulse, retriggered by each event.
// Assumes PULSE_CYC >= 1; dropping irq_en cancels the pulse at once.
module wkt_pulse #(
    parameter int PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic irq_en,
    output logic irq_n
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] LEN = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] remain;

    // Count down the remaining low cycles of the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (!irq_en) begin
            remain <= '0;
        end else if (trigger) begin
            remain <= LEN;
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign irq_n = (remain == '0) || !irq_en;

endmodule

// File: rtl/wakeup_timer.sv
// Top of the wakeup countdown timer: registers, source select, counter, pulse.
// Assumes tick inputs are synchronous one-cycle strobes from the prescaler.
module wakeup_timer
    import wkt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PRESET_W  = 16,
    parameter int PULSE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_4096,
    input  logic              tick_64,
    input  logic              tick_1hz,
    input  logic              tick_min,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              timer_flag,
    output logic              irq_n
);

    logic [PRESET_W-1:0] preset_w;
    ctrl_t               ctrl_w;
    logic                expire_w;
    logic                src_tick_w;
    logic                run_w;
    logic                ie_w;
    logic [NUM_SRC-1:0]  tick_vec;

    assign tick_vec = {tick_min, tick_1hz, tick_64, tick_4096};
    assign run_w    = ctrl_w.run;
    assign ie_w     = ctrl_w.irq_en;

    wkt_regs #(.DATA_W(DATA_W), .PRESET_W(PRESET_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .expire  (expire_w),
        .preset  (preset_w),
        .ctrl    (ctrl_w),
        .flag    (timer_flag)
    );

    wkt_src_sel #(.NSRC(NUM_SRC), .SW(SEL_W)) u_sel (
        .ticks    (tick_vec),
        .sel      (ctrl_w.src),
        .src_tick (src_tick_w)
    );

    wkt_counter #(.PRESET_W(PRESET_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .src_tick (src_tick_w),
        .preset   (preset_w),
        .expire   (expire_w)
    );

    wkt_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (expire_w),
        .irq_en  (ie_w),
        .irq_n   (irq_n)
    );

endmodule

// File: rtl/wkt_checker.sv
// Property checker for the wakeup timer, bound into every instance.
// Assumes it sees the expiry strobe and control bits of the bound top.
module wkt_checker
    import wkt_pkg::*;
#(
    parameter int PULSE_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       wr_bit0,
    input logic       run,
    input logic       irq_en,
    input logic       expire,
    input logic       timer_flag,
    input logic       irq_n
);

    localparam int SW = $clog2(PULSE_CYC + 2);
    localparam logic [SW-1:0] CAP = SW'(PULSE_CYC);

    logic [SW-1:0] since_exp;
    logic          clr_wr;
    logic          ctrl_wr;

    assign clr_wr  = wr_en && (wr_addr == REG_FLAG) && !wr_bit0;
    assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);

    // Cycles since the last expiry, saturating at the pulse length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_exp <= CAP;
        end else if (expire) begin
            since_exp <= '0;
        end else if (since_exp != CAP) begin
            since_exp <= since_exp + SW'(1);
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_flag && !clr_wr) |=> timer_flag); // R5
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_flag) |-> $past(expire)); // R5
    AST_IRQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_en && !ctrl_wr) |=> !irq_n); // R6
    AST_IRQ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (since_exp < CAP)); // R6
    AST_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n); // R8
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expire); // R9

endmodule

bind wakeup_timer wkt_checker #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_bit0    (wr_data[0]),
    .run        (run_w),
    .irq_en     (ie_w),
    .expire     (expire_w),
    .timer_flag (timer_flag),
    .irq_n      (irq_n)
);

// File: tb/wakeup_timer_tb.sv
`timescale 1ns/1ps
module wakeup_timer_tb;

    localparam int PULSE = 8;

    typedef struct packed {
        logic [1:0]  src;
        logic [15:0] preset;
        logic        ie;
    } vec_t;

    // Stimulus table: source, preset, interrupt enable
    localparam vec_t VECS [0:4] = '{
        '{2'd0, 16'd3,     1'b1},
        '{2'd1, 16'd1,     1'b1},
        '{2'd2, 16'd5,     1'b0},
        '{2'd3, 16'h0102,  1'b1},
        '{2'd0, 16'd0,     1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tk = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       timer_flag;
    logic       irq_n;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    wakeup_timer #(.DATA_W(8), .PRESET_W(16), .PULSE_CYC(PULSE)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_4096  (tk[0]),
        .tick_64    (tk[1]),
        .tick_1hz   (tk[2]),
        .tick_min   (tk[3]),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .timer_flag (timer_flag),
        .irq_n      (irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Pulse one tick input; returns two falling edges after the sampling edge
    task automatic tick(input int idx);
        @(negedge clk);
        tk[idx] = 1'b1;
        @(negedge clk);
        tk = '0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ctrl_byte(input logic ie, input logic [1:0] s,
                                             input logic run);
        return {4'b0, ie, s, run};
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 flag after reset", int'(timer_flag), 0);
        chk("R1 irq after reset", int'(irq_n), 1);

        // Table-driven runs across sources, presets and enables (R2 R3 R4 R11)
        foreach (VECS[k]) begin
            vec_t v = VECS[k];
            int   s = int'(v.src);
            int   decoy = (s + 1) % 4;
            wr(2'd2, 8'h00);
            wr(2'd3, 8'h00);
            idle(PULSE + 2);
            wr(2'd0, v.preset[7:0]);
            wr(2'd1, v.preset[15:8]);
            wr(2'd2, ctrl_byte(v.ie, v.src, 1'b1));
            if (v.preset == 16'd0) begin
                for (int i = 0; i < 6; i++) tick(s);
                chk("R10 zero preset never expires", int'(timer_flag), 0);
                chk("R10 zero preset irq", int'(irq_n), 1);
            end else begin
                for (int i = 0; i < int'(v.preset); i++) begin
                    tick(s);
                    tick(decoy);
                end
                chk("R3 R2 no expiry before tick P+1", int'(timer_flag), 0);
                tick(s);
                chk("R3 expiry on tick P+1", int'(timer_flag), 1);
                chk("R6 R8 irq level at expiry", int'(irq_n), v.ie ? 0 : 1);
                idle(PULSE - 1);
                chk("R6 R8 irq at last pulse cycle", int'(irq_n), v.ie ? 0 : 1);
                idle(1);
                chk("R6 irq released after pulse", int'(irq_n), 1);
                chk("R5 flag sticky after pulse", int'(timer_flag), 1);
                wr(2'd3, 8'h00);
                chk("R5 flag cleared by zero write", int'(timer_flag), 0);
                for (int i = 0; i < int'(v.preset) - 1; i++) tick(s);
                chk("R4 no early periodic expiry", int'(timer_flag), 0);
                tick(s);
                chk("R4 periodic expiry after P ticks", int'(timer_flag), 1);
            end
        end

        // Directed: clear during pulse keeps the pulse (R7)
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        idle(PULSE + 2);
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd0);
        wr(2'd2, ctrl_byte(1'b1, 2'd0, 1'b1));
        for (int i = 0; i < 3; i++) tick(0);
        chk("R7 flag set before clear", int'(timer_flag), 1);
        wr(2'd3, 8'h00);
        chk("R7 flag cleared", int'(timer_flag), 0);
        chk("R7 irq still low after clear", int'(irq_n), 0);

        // Directed: writing 1 to the flag has no effect (R5)
        tick(0);
        tick(0);
        chk("R5 flag set again", int'(timer_flag), 1);
        wr(2'd3, 8'h01);
        chk("R5 write of one keeps flag", int'(timer_flag), 1);
        wr(2'd3, 8'h00);
        wr(2'd3, 8'h01);
        chk("R5 write of one does not set", int'(timer_flag), 0);

        // Directed: stop and restart (R9)
        wr(2'd2, ctrl_byte(1'b1, 2'd0, 1'b0));
        idle(PULSE + 2);
        for (int i = 0; i < 8; i++) tick(0);
        chk("R9 stopped timer no flag", int'(timer_flag), 0);
        chk("R9 stopped timer irq", int'(irq_n), 1);
        wr(2'd2, ctrl_byte(1'b1, 2'd0, 1'b1));
        tick(0);
        tick(0);
        chk("R9 restart reloads before counting", int'(timer_flag), 0);
        tick(0);
        chk("R9 restart expires on tick P+1", int'(timer_flag), 1);

        summary();
    end

endmodule